// File: doc/BRIEF.md
# Multiport Register File with Scan Chain

This block is a 32-word by 64-bit register file for a wide-issue datapath. Two write ports and six read ports all work in the same clock cycle. Each write port has an enable, a word address and a data word, and the write takes effect at the rising clock edge. Each read port takes a word address and returns the stored word combinationally within the same cycle.

The words are held in four quadrants of eight words each. For every read port, each quadrant produces its own partial result. A quadrant that is not addressed produces zero. The four partial results are OR-merged into the port's output.

A serial scan mode makes every storage bit reachable through one shift chain, so the array can be loaded and unloaded without a self-test engine. A synchronous reset clears the whole array.

Top module: `regfile_2w6r`

## Requirements
- R1: When `rst` is high at a rising edge, every word becomes zero. Reset takes precedence over scan and writes.
- R2: With `scan_en` low, an enabled write port stores its data at its address on the rising edge, and the new value is readable from the next cycle. A port whose enable is low changes nothing.
- R3: When both write ports are enabled with the same address, the word stores port 0's data. When their addresses differ, both words are stored in the same cycle.
- R4: The six read ports are independent, and each can read any word in the same cycle as the others. Port p uses address bits `rd_addr[5p+4:5p]` and data bits `rd_data[64p+63:64p]`.
- R5: A read of a word that is being written in the same cycle returns the contents from before the write.
- R6: Address bits [4:3] pick the quadrant and bits [2:0] pick the word within it. Each of the 32 addresses reaches its own word. Non-addressed quadrants contribute zero to the OR-merged output.
- R7: While `scan_en` is high, both write ports are ignored, even when enabled.
- R8: While `scan_en` is high, the 2048 bits form one chain ordered by flat index 64*word+bit. On each edge, `scan_in` enters word 0 bit 0 and every bit moves to the next higher index. `scan_out` always shows word 31 bit 63.
- R9: After 2048 scan shifts, the array holds exactly the shifted-in stream, and it can be read through the read ports. The first bit shifted in lands in word 31 bit 63.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, clears all words |
| we0 | input | 1 | Write enable, port 0 (higher priority) |
| wa0 | input | 5 | Write address, port 0 |
| wd0 | input | 64 | Write data, port 0 |
| we1 | input | 1 | Write enable, port 1 |
| wa1 | input | 5 | Write address, port 1 |
| wd1 | input | 64 | Write data, port 1 |
| rd_addr | input | 30 | Six packed 5-bit read addresses |
| rd_data | output | 384 | Six packed 64-bit read results |
| scan_en | input | 1 | Scan shift mode, blocks writes |
| scan_in | input | 1 | Serial scan input into word 0 bit 0 |
| scan_out | output | 1 | Serial scan output from word 31 bit 63 |

## Verification
A corrupted word, or a write that lands at the wrong address, shows up on any read port in the cycle after the faulty edge. The bench reads through all six ports every cycle, so such errors surface within a cycle or two of the cause. A wrong quadrant decode makes one word alias onto another, or OR junk into an output, and the all-distinct fill exposes this. A broken scan chain shows on `scan_out` as soon as the bad bit reaches the end of the chain. A full-length load, read back through the ports, pins down any misordered link.

// File: rtl/regfile_2w6r.sv
module regfile_2w6r #(
  parameter int WORDS = 32,
  parameter int WIDTH = 64,
  parameter int QUADS = 4,
  parameter int NRD   = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we0,
  input  logic [$clog2(WORDS)-1:0] wa0,
  input  logic [WIDTH-1:0]        wd0,
  input  logic                    we1,
  input  logic [$clog2(WORDS)-1:0] wa1,
  input  logic [WIDTH-1:0]        wd1,
  input  logic [NRD*$clog2(WORDS)-1:0] rd_addr,
  output logic [NRD*WIDTH-1:0]    rd_data,
  input  logic                    scan_en,
  input  logic                    scan_in,
  output logic                    scan_out
);
  localparam int AW     = $clog2(WORDS);
  localparam int QW     = $clog2(QUADS);
  localparam int LW     = AW - QW;
  localparam int QDEPTH = WORDS / QUADS;
  localparam int BITS   = WORDS * WIDTH;

  logic [BITS-1:0] cells;

  always_ff @(posedge clk) begin
    if (rst) begin
      cells <= '0;
    end else if (scan_en) begin
      cells <= {cells[BITS-2:0], scan_in};
    end else begin
      if (we1) cells[wa1*WIDTH +: WIDTH] <= wd1;
      if (we0) cells[wa0*WIDTH +: WIDTH] <= wd0;
    end
  end

  assign scan_out = cells[BITS-1];

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    logic [AW-1:0]    addr;
    logic [WIDTH-1:0] part [QUADS];
    logic [WIDTH-1:0] merged;

    assign addr = rd_addr[p*AW +: AW];

    for (genvar q = 0; q < QUADS; q++) begin : g_quad
      logic hit;
      assign hit = (addr[AW-1:LW] == QW'(q));
      assign part[q] = hit ? cells[(q*QDEPTH + int'(addr[LW-1:0]))*WIDTH +: WIDTH]
                           : '0;
    end

    always_comb begin
      merged = '0;
      for (int q = 0; q < QUADS; q++) merged = merged | part[q];
    end

    assign rd_data[p*WIDTH +: WIDTH] = merged;
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (cells == '0));

  assert_port1_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && we1 && !(we0 && wa0 == wa1))
      |=> (cells[$past(wa1)*WIDTH +: WIDTH] == $past(wd1)));

  assert_port0_wins_R3: assert property (@(posedge clk) disable iff (rst)
    (!scan_en && we0)
      |=> (cells[$past(wa0)*WIDTH +: WIDTH] == $past(wd0)));

  assert_scan_blocks_write_R7: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> (cells[BITS-1:1] == $past(cells[BITS-2:0])));

  assert_scan_entry_R8: assert property (@(posedge clk) disable iff (rst)
    scan_en |=> (cells[0] == $past(scan_in)));
endmodule

// File: tb/tb_regfile_2w6r.sv
module tb_regfile_2w6r;
  localparam int WORDS = 32;
  localparam int WIDTH = 64;
  localparam int NRD   = 6;
  localparam int AW    = 5;
  localparam int BITS  = WORDS * WIDTH;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic we0 = 1'b0, we1 = 1'b0;
  logic [AW-1:0] wa0 = '0, wa1 = '0;
  logic [WIDTH-1:0] wd0 = '0, wd1 = '0;
  logic [NRD*AW-1:0] rd_addr = '0;
  logic [NRD*WIDTH-1:0] rd_data;
  logic scan_en = 1'b0, scan_in = 1'b0;
  logic scan_out;

  logic [BITS-1:0] model;
  int errors = 0;
  int checks = 0;
  logic [BITS-1:0] stream;

  regfile_2w6r dut (
    .clk(clk), .rst(rst), .we0(we0), .wa0(wa0), .wd0(wd0),
    .we1(we1), .wa1(wa1), .wd1(wd1), .rd_addr(rd_addr), .rd_data(rd_data),
    .scan_en(scan_en), .scan_in(scan_in), .scan_out(scan_out)
  );

  always #10 clk = ~clk;

  function automatic logic [WIDTH-1:0] exp_word(input logic [AW-1:0] a);
    return model[a*WIDTH +: WIDTH];
  endfunction

  function automatic logic [WIDTH-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  task automatic check(input string tag, input logic [WIDTH-1:0] got,
                       input logic [WIDTH-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic check_reads(input string tag);
    for (int p = 0; p < NRD; p++)
      check(tag, rd_data[p*WIDTH +: WIDTH], exp_word(rd_addr[p*AW +: AW]));
  endtask

  task automatic step();
    @(posedge clk);
    if (rst) model = '0;
    else if (scan_en) model = {model[BITS-2:0], scan_in};
    else begin
      if (we1) model[wa1*WIDTH +: WIDTH] = wd1;
      if (we0) model[wa0*WIDTH +: WIDTH] = wd0;
    end
    @(negedge clk);
  endtask

  task automatic read_all(input string tag);
    we0 = 0; we1 = 0;
    for (int base = 0; base < WORDS; base += NRD) begin
      for (int p = 0; p < NRD; p++) rd_addr[p*AW +: AW] = AW'((base + p) % WORDS);
      #1 check_reads(tag);
      step();
    end
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    model = '0;
    @(negedge clk);
    step(); step();
    rst = 0;
    read_all("R1 reset state");

    // R3 collision, port 0 wins
    we0 = 1; we1 = 1; wa0 = 5'd13; wa1 = 5'd13;
    wd0 = 64'hAAAA_0000_1111_2222; wd1 = 64'h5555_FFFF_EEEE_DDDD;
    step();
    we0 = 0; we1 = 0; rd_addr[0 +: AW] = 5'd13;
    #1 check("R3 port0 priority", rd_data[0 +: WIDTH], 64'hAAAA_0000_1111_2222);
    // R3 distinct addresses both stored
    we0 = 1; we1 = 1; wa0 = 5'd2; wa1 = 5'd30;
    wd0 = 64'h0123_4567_89AB_CDEF; wd1 = 64'hFEDC_BA98_7654_3210;
    step();
    we0 = 0; we1 = 0; rd_addr[0 +: AW] = 5'd2; rd_addr[AW +: AW] = 5'd30;
    #1 check("R3 dual write p0", rd_data[0 +: WIDTH], 64'h0123_4567_89AB_CDEF);
    check("R3 dual write p1", rd_data[WIDTH +: WIDTH], 64'hFEDC_BA98_7654_3210);

    // R5 directed: read during write returns old value
    we0 = 1; wa0 = 5'd2; wd0 = 64'hDEAD_BEEF_0000_0001; rd_addr[0 +: AW] = 5'd2;
    #1 check("R5 read old during write", rd_data[0 +: WIDTH], 64'h0123_4567_89AB_CDEF);
    step();
    we0 = 0;
    #1 check("R2 new value next cycle", rd_data[0 +: WIDTH], 64'hDEAD_BEEF_0000_0001);

    // R6 distinct fill of every word, then read back
    for (int w = 0; w < WORDS; w += 2) begin
      we0 = 1; wa0 = AW'(w);   wd0 = {32'(w) ^ 32'hC0DE_0000, 32'(w * 7)};
      we1 = 1; wa1 = AW'(w+1); wd1 = {32'(w+1) ^ 32'hC0DE_0000, 32'((w+1) * 7)};
      step();
    end
    read_all("R6 quadrant decode");

    // Random mixed traffic: R2 R4 R5
    for (int i = 0; i < 600; i++) begin
      we0 = 1'($urandom); we1 = 1'($urandom);
      wa0 = AW'($urandom); wa1 = (($urandom % 4) == 0) ? wa0 : AW'($urandom);
      wd0 = rnd64(); wd1 = rnd64();
      for (int p = 0; p < NRD; p++)
        rd_addr[p*AW +: AW] = (($urandom % 5) == 0) ? wa0 : AW'($urandom);
      #1 check_reads((we0 && rd_addr[0 +: AW] == wa0) ? "R5 same-cycle read" : "R4 random read");
      step();
    end
    we0 = 0; we1 = 0;
    read_all("R2 random writes settled");

    // R7 writes ignored under scan; R8 chain order
    scan_en = 1;
    for (int i = 0; i < BITS; i++) begin
      stream[i] = 1'($urandom);
      scan_in = stream[i];
      we0 = 1; we1 = 1; wa0 = AW'($urandom); wa1 = AW'($urandom);
      wd0 = rnd64(); wd1 = rnd64();
      #1 checks++;
      if (scan_out !== model[BITS-1]) begin
        errors++;
        $display("FAIL R8 scan_out: got %b expected %b", scan_out, model[BITS-1]);
      end
      step();
    end
    scan_en = 0; we0 = 0; we1 = 0;
    // R9: first bit in ends at word 31 bit 63
    rd_addr[0 +: AW] = 5'd31;
    #1 check("R9 first bit at top", {63'd0, rd_data[WIDTH-1]}, {63'd0, stream[0]});
    read_all("R7 R9 scan load");

    // R1 reset after content
    rst = 1; step(); rst = 0;
    read_all("R1 reset clears");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule